// File: doc/BRIEF.md
# Cache Line Snoop Responder

This block is the snoop side of one cache's tag array. Every memory transaction on the shared bus is presented to it, including transactions started by the agent that owns the cache. There is no originator qualifier: every accepted request is looked up the same way. The block reads the line's coherence state (Invalid, Shared, Exclusive or Modified) from a direct-mapped tag and state array. It reports a clean hit, a modified hit or a miss, and then moves the line to its next state according to the transaction kind.

Four transaction kinds are handled: a plain read, a write, a read-for-ownership of a full line, and a zero-length ownership claim. A zero-length claim is only legal when the requester already shares the line. When a modified line is hit, the block runs an implicit writeback. It waits for the target to say it is ready, then streams the line out as fixed-size beats over a valid/ready handshake. The beats are read from an external data array through an index/beat select. The cache's own allocation logic installs lines through a fill port.

Top module: `snoop_agent`

## Requirements
- R1: After reset the block sweeps every set to Invalid while holding `snp_rdy` low. `rpt_vld` stays low and any snoop afterwards reports a miss, including lines filled before the reset.
- R2: A request strobed while `snp_rdy` is high produces exactly one `rpt_vld` pulse, two cycles after the strobe cycle. `snp_rdy` is low in the cycle between. `rpt_hit` and `rpt_hitm` are never both high, and all report bits are low when `rpt_vld` is low.
- R3: A read (`snp_type`=0) that hits a Shared or Exclusive line reports a clean hit (`rpt_hit`=1) with no writeback, and leaves the line Shared.
- R4: A read that hits a Modified line reports a modified hit (`rpt_hitm`=1), writes the line back, and leaves it Shared.
- R5: A write (`snp_type`=1) that hits a Shared or Exclusive line reports a miss and invalidates the line.
- R6: A write that hits a Modified line reports a modified hit and writes the line back, then invalidates it. No beat is offered before `wb_go` is seen high.
- R7: A full-line read-for-ownership (`snp_type`=2) reports a miss and invalidates a Shared or Exclusive line. On a Modified line it reports a modified hit, writes the line back and invalidates it.
- R8: A zero-length claim (`snp_type`=3) that hits a Shared line reports a miss and invalidates it.
- R9: A zero-length claim that hits an Exclusive or Modified line raises `rpt_err` with both hit bits low, starts no writeback and leaves the line unchanged.
- R10: A snoop whose tag differs from the stored tag, or whose set is Invalid, reports a miss and leaves the stored line unchanged.
- R11: A writeback sends `BEATS` beats with `wb_beat` counting up from 0. `wb_data` is `dat_rdata` for (`wb_idx`, `wb_beat`), and a beat is held while `wb_ready` is low. The line state changes, and `snp_rdy` returns high, only on the edge that accepts the last beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| snp_req | input | 1 | Snoop request strobe, taken when `snp_rdy` is high |
| snp_type | input | 2 | 0 read, 1 write, 2 full-line read-for-ownership, 3 zero-length claim |
| snp_addr | input | ADDR_W | Line address; low IDX_W bits select the set, the rest is the tag |
| snp_rdy | output | 1 | Block idle and able to take a request or a fill |
| rpt_vld | output | 1 | Snoop report valid pulse |
| rpt_hit | output | 1 | Clean hit |
| rpt_hitm | output | 1 | Modified hit, writeback follows |
| rpt_err | output | 1 | Illegal zero-length claim |
| fill_we | input | 1 | Install a line; honoured only while `snp_rdy` is high |
| fill_addr | input | ADDR_W | Line address to install |
| fill_state | input | 2 | State to install: 0 I, 1 S, 2 E, 3 M |
| wb_go | input | 1 | Target ready to accept the implicit writeback |
| wb_valid | output | 1 | Writeback beat valid |
| wb_ready | input | 1 | Writeback beat accepted |
| wb_data | output | DATA_W | Writeback beat data |
| wb_beat | output | BEAT_W | Beat number, also the data array beat select |
| wb_idx | output | IDX_W | Set being written back, data array row select |
| dat_rdata | input | DATA_W | Data array word for (`wb_idx`, `wb_beat`) |

## Verification
The hardest behaviour to reach is the final state that a transaction leaves behind. The state array has no read port at the edge, and a probe snoop can itself change the line. The stimulus places one table row per set, installs the starting state through the fill port, and applies the transaction under test. It then issues a read probe whose answer (miss, clean hit or modified hit) tells Invalid, Shared-or-Exclusive and Modified apart. Exclusive and Shared are told apart by a zero-length claim, which flags an error only on Exclusive. Writebacks are driven with a delayed target-ready and a stalled beat, to show the hold and the late state update.

// File: rtl/snp_pkg.sv
package snp_pkg;
  typedef enum logic [1:0] {LS_I = 2'd0, LS_S = 2'd1, LS_E = 2'd2, LS_M = 2'd3} line_st_t;
  typedef enum logic [1:0] {TX_RD = 2'd0, TX_WR = 2'd1, TX_RDINV = 2'd2, TX_KILL = 2'd3} tx_t;
  typedef struct packed {
    logic     hit;
    logic     hitm;
    logic     err;
    logic     wr_arr;
    logic     need_wb;
    line_st_t nxt;
  } verdict_t;
endpackage

// File: rtl/snp_tag_ram.sv
module snp_tag_ram #(
  parameter int IDX_W = 4,
  parameter int ENT_W = 10
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [ENT_W-1:0] wdata,
  input  logic             re,
  input  logic [IDX_W-1:0] raddr,
  output logic [ENT_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;
  logic [ENT_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/snp_policy.sv
module snp_policy
  import snp_pkg::*;
(
  input  tx_t      ty,
  input  line_st_t cur,
  input  logic     tag_eq,
  output verdict_t v
);
  logic present;
  assign present = tag_eq && (cur != LS_I);

  always_comb begin
    v     = '0;
    v.nxt = cur;
    if (present) begin
      unique case (ty)
        TX_RD: begin
          if (cur == LS_M) begin
            v.hitm = 1'b1; v.need_wb = 1'b1; v.nxt = LS_S;
          end else begin
            v.hit = 1'b1; v.wr_arr = (cur == LS_E); v.nxt = LS_S;
          end
        end
        TX_WR, TX_RDINV: begin
          if (cur == LS_M) begin
            v.hitm = 1'b1; v.need_wb = 1'b1; v.nxt = LS_I;
          end else begin
            v.wr_arr = 1'b1; v.nxt = LS_I;
          end
        end
        TX_KILL: begin
          if (cur == LS_S) begin
            v.wr_arr = 1'b1; v.nxt = LS_I;
          end else begin
            v.err = 1'b1;
          end
        end
        default: v = '0;
      endcase
    end
  end

  // R9
  always_comb begin
    kill_safe_chk: assert (!(v.err && (v.wr_arr || v.need_wb)));
  end
endmodule

// File: rtl/snp_wb_seq.sv
module snp_wb_seq #(
  parameter int IDX_W = 4,
  parameter int BEATS = 4,
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [IDX_W-1:0]  start_idx,
  input  logic              go,
  input  logic              wb_ready,
  output logic              wb_valid,
  output logic [BEAT_W-1:0] wb_beat,
  output logic [IDX_W-1:0]  wb_idx,
  output logic              done
);
  localparam logic [BEAT_W-1:0] LAST = BEAT_W'(BEATS - 1);
  typedef enum logic [1:0] {W_IDLE, W_WAIT, W_SEND} wst_t;
  wst_t wst;

  always_ff @(posedge clk) begin
    if (rst) begin
      wst      <= W_IDLE;
      wb_valid <= 1'b0;
      wb_beat  <= '0;
      wb_idx   <= '0;
    end else begin
      unique case (wst)
        W_IDLE: if (start) begin
          wb_idx <= start_idx;
          wst    <= W_WAIT;
        end
        W_WAIT: if (go) begin
          wst      <= W_SEND;
          wb_valid <= 1'b1;
          wb_beat  <= '0;
        end
        W_SEND: if (wb_valid && wb_ready) begin
          if (wb_beat == LAST) begin
            wb_valid <= 1'b0;
            wst      <= W_IDLE;
          end else begin
            wb_beat <= wb_beat + 1'b1;
          end
        end
        default: wst <= W_IDLE;
      endcase
    end
  end

  assign done = (wst == W_SEND) && wb_valid && wb_ready && (wb_beat == LAST);

  // R11
  wb_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_beat)));
  // R6
  wb_after_go_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wb_valid) |-> $past(go));
endmodule

// File: rtl/snoop_agent.sv
module snoop_agent
  import snp_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 4,
  parameter int DATA_W = 64,
  parameter int BEATS  = 4,
  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              snp_req,
  input  logic [1:0]        snp_type,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_rdy,
  output logic              rpt_vld,
  output logic              rpt_hit,
  output logic              rpt_hitm,
  output logic              rpt_err,
  input  logic              fill_we,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [1:0]        fill_state,
  input  logic              wb_go,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [DATA_W-1:0] wb_data,
  output logic [BEAT_W-1:0] wb_beat,
  output logic [IDX_W-1:0]  wb_idx,
  input  logic [DATA_W-1:0] dat_rdata
);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int ENT_W = TAG_W + 2;
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [IDX_W-1:0] CLR_LAST = IDX_W'(DEPTH - 1);

  typedef enum logic [1:0] {A_INIT, A_IDLE, A_LOOK, A_WB} ast_t;
  ast_t st;

  logic [IDX_W-1:0] clr_cnt;
  logic [IDX_W-1:0] q_idx;
  logic [TAG_W-1:0] q_tag;
  tx_t              q_ty;
  line_st_t         held_nxt;

  logic             ram_we;
  logic [IDX_W-1:0] ram_waddr;
  logic [ENT_W-1:0] ram_wdata;
  logic             ram_re;
  logic [ENT_W-1:0] ram_rdata;

  verdict_t         vd;
  logic             wb_start;
  logic             wb_done;
  logic             tag_eq;
  line_st_t         cur_st;

  assign snp_rdy = (st == A_IDLE);
  assign ram_re  = snp_req && (st == A_IDLE);
  assign cur_st  = line_st_t'(ram_rdata[1:0]);
  assign tag_eq  = (ram_rdata[ENT_W-1:2] == q_tag);

  always_comb begin
    ram_we    = 1'b0;
    ram_waddr = q_idx;
    ram_wdata = {q_tag, 2'(LS_I)};
    unique case (st)
      A_INIT: begin
        ram_we    = 1'b1;
        ram_waddr = clr_cnt;
        ram_wdata = {{TAG_W{1'b0}}, 2'(LS_I)};
      end
      A_LOOK: begin
        ram_we    = vd.wr_arr;
        ram_wdata = {q_tag, 2'(vd.nxt)};
      end
      A_WB: begin
        ram_we    = wb_done;
        ram_wdata = {q_tag, 2'(held_nxt)};
      end
      default: begin
        ram_we    = fill_we;
        ram_waddr = fill_addr[IDX_W-1:0];
        ram_wdata = {fill_addr[ADDR_W-1:IDX_W], fill_state};
      end
    endcase
  end

  snp_tag_ram #(.IDX_W(IDX_W), .ENT_W(ENT_W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .re    (ram_re),
    .raddr (snp_addr[IDX_W-1:0]),
    .rdata (ram_rdata)
  );

  snp_policy u_pol (
    .ty     (q_ty),
    .cur    (cur_st),
    .tag_eq (tag_eq),
    .v      (vd)
  );

  assign wb_start = (st == A_LOOK) && vd.need_wb;

  snp_wb_seq #(.IDX_W(IDX_W), .BEATS(BEATS)) u_wb (
    .clk       (clk),
    .rst       (rst),
    .start     (wb_start),
    .start_idx (q_idx),
    .go        (wb_go),
    .wb_ready  (wb_ready),
    .wb_valid  (wb_valid),
    .wb_beat   (wb_beat),
    .wb_idx    (wb_idx),
    .done      (wb_done)
  );

  assign wb_data = dat_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= A_INIT;
      clr_cnt  <= '0;
      q_idx    <= '0;
      q_tag    <= '0;
      q_ty     <= TX_RD;
      held_nxt <= LS_I;
      rpt_vld  <= 1'b0;
      rpt_hit  <= 1'b0;
      rpt_hitm <= 1'b0;
      rpt_err  <= 1'b0;
    end else begin
      rpt_vld  <= 1'b0;
      rpt_hit  <= 1'b0;
      rpt_hitm <= 1'b0;
      rpt_err  <= 1'b0;
      unique case (st)
        A_INIT: begin
          clr_cnt <= clr_cnt + 1'b1;
          if (clr_cnt == CLR_LAST) st <= A_IDLE;
        end
        A_IDLE: if (snp_req) begin
          q_idx <= snp_addr[IDX_W-1:0];
          q_tag <= snp_addr[ADDR_W-1:IDX_W];
          q_ty  <= tx_t'(snp_type);
          st    <= A_LOOK;
        end
        A_LOOK: begin
          rpt_vld  <= 1'b1;
          rpt_hit  <= vd.hit;
          rpt_hitm <= vd.hitm;
          rpt_err  <= vd.err;
          held_nxt <= vd.nxt;
          st       <= vd.need_wb ? A_WB : A_IDLE;
        end
        A_WB: if (wb_done) st <= A_IDLE;
        default: st <= A_IDLE;
      endcase
    end
  end

  // R2
  rpt_timing_chk: assert property (@(posedge clk) disable iff (rst)
    rpt_vld |-> $past(st == A_LOOK));
  // R2
  rpt_excl_chk: assert property (@(posedge clk) disable iff (rst)
    rpt_vld |-> !(rpt_hit && rpt_hitm));
  // R2
  rpt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !rpt_vld |-> !(rpt_hit || rpt_hitm || rpt_err));
  // R9
  err_no_hit_chk: assert property (@(posedge clk) disable iff (rst)
    rpt_err |-> !(rpt_hit || rpt_hitm));
  // R11
  busy_in_wb_chk: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> !snp_rdy);
  // R1
  init_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (st == A_INIT) |-> !snp_rdy && !rpt_vld);
endmodule

// File: tb/sim_snoop_agent.sv
`timescale 1ns/1ps
module sim_snoop_agent;
  localparam int ADDR_W = 12;
  localparam int IDX_W  = 4;
  localparam int DATA_W = 64;
  localparam int BEATS  = 4;
  localparam int BEAT_W = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic snp_req = 1'b0;
  logic [1:0] snp_type = '0;
  logic [ADDR_W-1:0] snp_addr = '0;
  logic snp_rdy, rpt_vld, rpt_hit, rpt_hitm, rpt_err;
  logic fill_we = 1'b0;
  logic [ADDR_W-1:0] fill_addr = '0;
  logic [1:0] fill_state = '0;
  logic wb_go = 1'b0;
  logic wb_valid;
  logic wb_ready = 1'b0;
  logic [DATA_W-1:0] wb_data;
  logic [BEAT_W-1:0] wb_beat;
  logic [IDX_W-1:0] wb_idx;
  logic [DATA_W-1:0] dat_rdata;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  assign dat_rdata = {28'hCAFE000, wb_idx, 30'h0, wb_beat};

  snoop_agent #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W), .BEATS(BEATS)) u0 (
    .clk(clk), .rst(rst), .snp_req(snp_req), .snp_type(snp_type), .snp_addr(snp_addr),
    .snp_rdy(snp_rdy), .rpt_vld(rpt_vld), .rpt_hit(rpt_hit), .rpt_hitm(rpt_hitm),
    .rpt_err(rpt_err), .fill_we(fill_we), .fill_addr(fill_addr), .fill_state(fill_state),
    .wb_go(wb_go), .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_data(wb_data),
    .wb_beat(wb_beat), .wb_idx(wb_idx), .dat_rdata(dat_rdata)
  );

  // row: {state[1:0], type[1:0], hit, hitm, err, probe_hit, probe_hitm}
  localparam logic [8:0] VEC [16] = '{
    9'b00_00_000_00, 9'b01_00_100_10, 9'b10_00_100_10, 9'b11_00_010_10,
    9'b00_01_000_00, 9'b01_01_000_00, 9'b10_01_000_00, 9'b11_01_010_00,
    9'b00_10_000_00, 9'b01_10_000_00, 9'b10_10_000_00, 9'b11_10_010_00,
    9'b00_11_000_00, 9'b01_11_000_00, 9'b10_11_001_10, 9'b11_11_001_01
  };

  task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic wait_rdy();
    @(negedge clk);
    while (!snp_rdy) @(negedge clk);
  endtask

  task automatic fill(input logic [ADDR_W-1:0] a, input logic [1:0] s);
    wait_rdy();
    fill_we = 1'b1; fill_addr = a; fill_state = s;
    @(negedge clk);
    fill_we = 1'b0;
  endtask

  task automatic snoop(input logic [1:0] ty, input logic [ADDR_W-1:0] a,
                       output logic h, output logic hm, output logic e);
    wait_rdy();
    snp_req = 1'b1; snp_type = ty; snp_addr = a;
    @(negedge clk);
    snp_req = 1'b0;
    chk("R2", "report early", {63'b0, rpt_vld}, 64'd0);
    chk("R2", "rdy during lookup", {63'b0, snp_rdy}, 64'd0);
    @(negedge clk);
    chk("R2", "report valid", {63'b0, rpt_vld}, 64'd1);
    h = rpt_hit; hm = rpt_hitm; e = rpt_err;
  endtask

  task automatic writeback(input logic [IDX_W-1:0] idx, input string rq);
    wb_go = 1'b0; wb_ready = 1'b1;
    repeat (2) begin
      @(negedge clk);
      chk("R6", "beat before go", {63'b0, wb_valid}, 64'd0);
    end
    wb_go = 1'b1;
    @(negedge clk);
    wb_go = 1'b0;
    for (int k = 0; k < BEATS; k++) begin
      chk(rq, "beat valid", {63'b0, wb_valid}, 64'd1);
      chk("R11", "beat number", {62'b0, wb_beat}, 64'(k));
      chk("R11", "beat data", wb_data, {28'hCAFE000, idx, 30'h0, 2'(k)});
      chk("R11", "rdy low in wb", {63'b0, snp_rdy}, 64'd0);
      if (k == 1) begin
        wb_ready = 1'b0;
        @(negedge clk);
        chk("R11", "stall hold valid", {63'b0, wb_valid}, 64'd1);
        chk("R11", "stall hold beat", {62'b0, wb_beat}, 64'd1);
        wb_ready = 1'b1;
      end
      @(negedge clk);
    end
    wb_ready = 1'b0;
    chk("R11", "valid after last", {63'b0, wb_valid}, 64'd0);
    chk("R11", "rdy after last", {63'b0, snp_rdy}, 64'd1);
  endtask

  function automatic string row_req(input logic [1:0] s, input logic [1:0] t);
    if (s == 2'd0) return "R10";
    case (t)
      2'd0: return (s == 2'd3) ? "R4" : "R3";
      2'd1: return (s == 2'd3) ? "R6" : "R5";
      2'd2: return "R7";
      default: return (s[1]) ? "R9" : "R8";
    endcase
  endfunction

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 50000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic h, hm, e;
    logic [ADDR_W-1:0] a;
    repeat (3) @(negedge clk);
    chk("R1", "rdy in reset", {63'b0, snp_rdy}, 64'd0);
    chk("R1", "vld in reset", {63'b0, rpt_vld}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "rdy during sweep", {63'b0, snp_rdy}, 64'd0);
    snoop(2'd0, 12'h7A3, h, hm, e);
    chk("R1", "cold read miss", {61'b0, h, hm, e}, 64'd0);

    for (int i = 0; i < 16; i++) begin
      logic [1:0] s, t;
      string rq;
      s = VEC[i][8:7]; t = VEC[i][6:5];
      rq = row_req(s, t);
      a = {8'h3C ^ 8'(i), 4'(i)};
      fill(a, s);
      snoop(t, a, h, hm, e);
      chk(rq, "report bits", {61'b0, h, hm, e}, {61'b0, VEC[i][4:2]});
      if (hm) writeback(4'(i), rq);
      snoop(2'd0, a, h, hm, e);
      chk(rq, "probe state", {62'b0, h, hm}, {62'b0, VEC[i][1:0]});
      if (hm) writeback(4'(i), rq);
    end

    // R3: exclusive line left shared by a read (a claim then raises no error)
    a = 12'h515;
    fill(a, 2'd2);
    snoop(2'd0, a, h, hm, e);
    chk("R3", "read hit on E", {61'b0, h, hm, e}, 64'b100);
    snoop(2'd3, a, h, hm, e);
    chk("R3", "line now shared", {61'b0, h, hm, e}, 64'd0);
    snoop(2'd0, a, h, hm, e);
    chk("R8", "claim invalidated", {62'b0, h, hm}, 64'd0);

    // R10: tag mismatch leaves the stored modified line alone
    fill(12'hA25, 2'd3);
    snoop(2'd1, 12'hB25, h, hm, e);
    chk("R10", "other tag write", {61'b0, h, hm, e}, 64'd0);
    snoop(2'd3, 12'hB25, h, hm, e);
    chk("R10", "other tag claim", {61'b0, h, hm, e}, 64'd0);
    snoop(2'd0, 12'hA25, h, hm, e);
    chk("R10", "stored line kept", {62'b0, h, hm}, 64'b01);
    if (hm) writeback(4'h5, "R4");

    // R1: reset clears lines filled earlier
    fill(12'h3C7, 2'd3);
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    snoop(2'd0, 12'h3C7, h, hm, e);
    chk("R1", "filled line cleared", {61'b0, h, hm, e}, 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule